// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Patcher

This block takes the result of a Reed-Solomon decode over one 512-byte sector and repairs the sector where it sits in a byte-wide RAM. The decoder output is a status word and up to four error words. The status word carries an error-found flag, an uncorrectable flag and an error count. Each error word names one symbol and gives a 9-bit flip mask for it. The sector is read as a packed stream of 9-bit symbols laid down least-significant bit first, so a symbol nearly always crosses a byte boundary. Every correction is therefore a two-byte read-modify-write.

A one-cycle `start` pulse captures the status and error words. The block then works through the reports in order. For each usable report it reads the two bytes the symbol covers and XORs the shifted mask into them as a little-endian 16-bit word. It then writes both bytes back, one byte per cycle, through a synchronous single port. When it finishes it raises `done` for one cycle, shows how many reports it applied and whether the sector was marked uncorrectable, and holds those results until the next start.

Top module: `rs_symbol_patcher`

## Requirements
- R1: Status bits are decoded as follows: bits 31:29 hold the error count, bit 1 the uncorrectable flag and bit 0 the error-found flag. In each 32-bit error word, bits 24:16 hold a one-based symbol position and bits 8:0 hold the XOR mask. Error word k sits in `err_words[32k+31:32k]`.
- R2: With the uncorrectable flag set, the block performs no RAM write, sets `uncorrectable` to 1 and reports `fix_count` 0.
- R3: With the uncorrectable flag clear and the error-found flag clear, the block performs no RAM write, reports `fix_count` 0, and `done` is high in the cycle after the second rising edge, counting the edge that samples `start` as the first.
- R4: A report whose one-based position is 0 is skipped. It changes no byte and does not add to `fix_count`.
- R5: For zero-based position p = position - 1, the low byte address is p + (p >> 3) and the bit offset is p & 7. The bytes at that address and the next one form a little-endian 16-bit word. The block XORs mask << offset into that word and writes back the low byte and then the high byte.
- R6: Reports are applied in index order, starting at 0, up to the status count. A count above 4 is treated as 4. Words beyond the count change nothing.
- R7: A byte write to an address of 512 or above is suppressed. The rest of that report is still applied, and the report still counts toward `fix_count`.
- R8: `busy` is low in idle. It is high from the cycle after `start` is sampled through the cycle in which `done` is high. `done` lasts exactly one cycle.
- R9: `fix_count` equals the number of reports applied. `fix_count` and `uncorrectable` hold their values after `done` until the next accepted start.
- R10: On the error path, `done` is high after 3 + 5·A + S rising edges, where A is the number of applied reports and S the number of skipped reports.
- R11: A `start` pulse while `busy` is high is ignored and does not alter the job in progress.
- R12: After reset, `busy`, `done`, `ram_en`, `ram_we`, `uncorrectable` and `fix_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job launch, sampled when idle |
| status_word | input | 32 | Decoder status: count, uncorrectable flag, error flag |
| err_words | input | 128 | Four packed error words, word 0 in the low bits |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| fix_count | output | 3 | Number of reports applied |
| uncorrectable | output | 1 | Sector flagged uncorrectable |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 10 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after an enabled read |

## Verification
The bench counts rising edges from the one that samples `start`. On the error path it expects `done` after 3 + 5·A + S edges, where each applied report adds five edges and each skipped report adds one. The fast paths for uncorrectable and no-error inputs expect `done` after two edges. Each check is sampled at the falling edge that follows the expected rising edge, so the registered outputs have settled before they are read. The sector contents are compared with a bit-level reference that flips bit 8·(p + p/8) + (p mod 8) + b for each set mask bit b. Once the job completes, `busy` is expected to drop at the next edge while the results stay held.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int ADDR_W  = 10;
  localparam int SYM_W   = 9;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_PARSE, S_SCAN, S_RD_LO, S_RD_HI, S_WR_LO, S_WR_HI, S_FIN
  } rsp_state_t;

  // low byte address of zero-based symbol p
  function automatic logic [ADDR_W-1:0] sym_byte_addr(input logic [SYM_W-1:0] p);
    return {1'b0, p} + {4'b0, p[SYM_W-1:3]};
  endfunction

  function automatic logic [2:0] sym_shift(input logic [SYM_W-1:0] p);
    return p[2:0];
  endfunction

  // XOR shifted mask into little-endian 16-bit pair
  function automatic logic [15:0] sym_patch(input logic [15:0] pair,
                                            input logic [SYM_W-1:0] mask,
                                            input logic [2:0] ofs);
    return pair ^ ({7'b0, mask} << ofs);
  endfunction
endpackage

// File: rtl/rsp_report_decode.sv
module rsp_report_decode
  import rsp_pkg::*;
(
  input  logic [WORD_W-1:0] err_word,
  output logic              pos_ok,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [2:0]        bit_ofs,
  output logic [SYM_W-1:0]  mask
);
  logic [SYM_W-1:0] pos_one;
  logic [SYM_W-1:0] pos_zero;
  logic             unused_fields;

  assign pos_one       = err_word[24:16];
  assign mask          = err_word[8:0];
  assign pos_ok        = (pos_one != '0);
  assign pos_zero      = pos_one - 1'b1;
  assign byte_addr     = sym_byte_addr(pos_zero);
  assign bit_ofs       = sym_shift(pos_zero);
  assign unused_fields = ^{err_word[31:25], err_word[15:9]};
endmodule

// File: rtl/rsp_patch_merge.sv
module rsp_patch_merge
  import rsp_pkg::*;
(
  input  logic [7:0]       lo_in,
  input  logic [7:0]       hi_in,
  input  logic [SYM_W-1:0] mask,
  input  logic [2:0]       bit_ofs,
  output logic [7:0]       lo_out,
  output logic [7:0]       hi_out
);
  logic [15:0] pair_new;
  assign pair_new = sym_patch({hi_in, lo_in}, mask, bit_ofs);
  assign lo_out   = pair_new[7:0];
  assign hi_out   = pair_new[15:8];
endmodule

// File: rtl/rsp_sequencer.sv
module rsp_sequencer
  import rsp_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_FIX      = 4,
  localparam int IDX_W       = $clog2(MAX_FIX + 1),
  localparam int SEL_W       = $clog2(MAX_FIX)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [WORD_W-1:0]         status_in,
  input  logic [MAX_FIX*WORD_W-1:0] err_in,
  output logic [WORD_W-1:0]         cur_word,
  input  logic                      pos_ok,
  input  logic [ADDR_W-1:0]         byte_addr,
  output logic [7:0]                lo_q,
  input  logic [7:0]                new_lo,
  input  logic [7:0]                new_hi,
  output logic                      ram_en,
  output logic                      ram_we,
  output logic [ADDR_W-1:0]         ram_addr,
  output logic [7:0]                ram_wdata,
  input  logic [7:0]                ram_rdata,
  output logic                      busy,
  output logic                      done,
  output logic [IDX_W-1:0]          fix_count,
  output logic                      uncorrectable
);
  rsp_state_t        state;
  logic [WORD_W-1:0] words_q [MAX_FIX];
  logic [CNT_W-1:0]  cnt_q;
  logic              unc_q, err_q;
  logic [IDX_W-1:0]  idx, lim_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        hi_new_q;
  logic              unused_status;

  // named internal events for the checks
  logic wr_lo_evt, wr_hi_evt, in_sector;

  assign unused_status = ^status_in[28:2];
  assign cur_word  = (idx < IDX_W'(MAX_FIX)) ? words_q[idx[SEL_W-1:0]] : '0;
  assign wr_lo_evt = (state == S_WR_LO);
  assign wr_hi_evt = (state == S_WR_HI);
  assign ram_en    = (state == S_RD_LO) || (state == S_RD_HI) || wr_lo_evt || wr_hi_evt;
  assign ram_addr  = ((state == S_RD_HI) || wr_hi_evt) ? addr_q + 1'b1 : addr_q;
  assign in_sector = (ram_addr < ADDR_W'(SECTOR_BYTES));
  assign ram_we    = (wr_lo_evt || wr_hi_evt) && in_sector;
  assign ram_wdata = wr_lo_evt ? new_lo : hi_new_q;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      cnt_q         <= '0;
      unc_q         <= 1'b0;
      err_q         <= 1'b0;
      idx           <= '0;
      lim_q         <= '0;
      addr_q        <= '0;
      lo_q          <= '0;
      hi_new_q      <= '0;
      fix_count     <= '0;
      uncorrectable <= 1'b0;
      for (int i = 0; i < MAX_FIX; i++) words_q[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cnt_q         <= status_in[31:29];
          unc_q         <= status_in[1];
          err_q         <= status_in[0];
          for (int i = 0; i < MAX_FIX; i++) words_q[i] <= err_in[i*WORD_W +: WORD_W];
          fix_count     <= '0;
          uncorrectable <= 1'b0;
          state         <= S_PARSE;
        end
        S_PARSE: begin
          idx   <= '0;
          lim_q <= (IDX_W'(cnt_q) > IDX_W'(MAX_FIX)) ? IDX_W'(MAX_FIX) : IDX_W'(cnt_q);
          if (unc_q) begin
            uncorrectable <= 1'b1;
            state         <= S_FIN;
          end else if (!err_q) begin
            state <= S_FIN;
          end else begin
            state <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (idx >= lim_q) begin
            state <= S_FIN;
          end else if (pos_ok) begin
            addr_q <= byte_addr;
            state  <= S_RD_LO;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_RD_LO: state <= S_RD_HI;
        S_RD_HI: begin
          lo_q  <= ram_rdata;
          state <= S_WR_LO;
        end
        S_WR_LO: begin
          hi_new_q <= new_hi;
          state    <= S_WR_HI;
        end
        S_WR_HI: begin
          idx       <= idx + 1'b1;
          fix_count <= fix_count + 1'b1;
          state     <= S_SCAN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R2
  unc_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorrectable && busy) |-> !ram_en);
  // R2
  unc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && uncorrectable) |-> (fix_count == '0));
  // R5
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_evt |-> ($past(wr_lo_evt) && ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));
  // R6
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fix_count <= IDX_W'(MAX_FIX)));
  // R7
  we_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr < ADDR_W'(SECTOR_BYTES)));
  // R11
  job_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cnt_q) && $stable(unc_q) && $stable(err_q)));
endmodule

// File: rtl/rs_symbol_patcher.sv
module rs_symbol_patcher
  import rsp_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_FIX      = 4,
  localparam int IDX_W       = $clog2(MAX_FIX + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [WORD_W-1:0]         status_word,
  input  logic [MAX_FIX*WORD_W-1:0] err_words,
  output logic                      busy,
  output logic                      done,
  output logic [IDX_W-1:0]          fix_count,
  output logic                      uncorrectable,
  output logic                      ram_en,
  output logic                      ram_we,
  output logic [ADDR_W-1:0]         ram_addr,
  output logic [7:0]                ram_wdata,
  input  logic [7:0]                ram_rdata
);
  logic [WORD_W-1:0] cur_word;
  logic              pos_ok;
  logic [ADDR_W-1:0] byte_addr;
  logic [2:0]        bit_ofs;
  logic [SYM_W-1:0]  mask;
  logic [7:0]        lo_q, new_lo, new_hi;

  rsp_report_decode u_decode (
    .err_word (cur_word),
    .pos_ok   (pos_ok),
    .byte_addr(byte_addr),
    .bit_ofs  (bit_ofs),
    .mask     (mask)
  );

  rsp_patch_merge u_merge (
    .lo_in  (lo_q),
    .hi_in  (ram_rdata),
    .mask   (mask),
    .bit_ofs(bit_ofs),
    .lo_out (new_lo),
    .hi_out (new_hi)
  );

  rsp_sequencer #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .MAX_FIX     (MAX_FIX)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .status_in    (status_word),
    .err_in       (err_words),
    .cur_word     (cur_word),
    .pos_ok       (pos_ok),
    .byte_addr    (byte_addr),
    .lo_q         (lo_q),
    .new_lo       (new_lo),
    .new_hi       (new_hi),
    .ram_en       (ram_en),
    .ram_we       (ram_we),
    .ram_addr     (ram_addr),
    .ram_wdata    (ram_wdata),
    .ram_rdata    (ram_rdata),
    .busy         (busy),
    .done         (done),
    .fix_count    (fix_count),
    .uncorrectable(uncorrectable)
  );
endmodule

// File: tb/rs_symbol_patcher_bench.sv
module rs_symbol_patcher_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  status_word = '0;
  logic [127:0] err_words = '0;
  logic         busy, done, uncorrectable, ram_en, ram_we;
  logic [2:0]   fix_count;
  logic [9:0]   ram_addr;
  logic [7:0]   ram_wdata;
  logic [7:0]   ram_rdata = '0;

  logic [7:0]   mem  [1024];
  logic [7:0]   gold [1024];
  int           checks = 0;
  int           failures = 0;
  int           wr_cnt = 0;
  int           oob_cnt = 0;

  always #10 clk = ~clk;

  rs_symbol_patcher u_rs_symbol_patcher (
    .clk(clk), .rst_n(rst_n), .start(start), .status_word(status_word),
    .err_words(err_words), .busy(busy), .done(done), .fix_count(fix_count),
    .uncorrectable(uncorrectable), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_en) begin
      ram_rdata <= mem[ram_addr];
      if (ram_we) begin
        mem[ram_addr] <= ram_wdata;
        wr_cnt = wr_cnt + 1;
        if (ram_addr >= 10'd512) oob_cnt = oob_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ew(input logic [8:0] pos1, input logic [8:0] m);
    return {7'b0, pos1, 7'b0, m};
  endfunction

  function automatic logic [31:0] st(input logic [2:0] cnt, input bit unc, input bit err);
    return {cnt, 27'b0, unc, err};
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'((i * 37 + seed) & 255);
      gold[i] = mem[i];
    end
  endtask

  // bit-level reference: flip stream bits; returns 1 when the report applies
  function automatic int gold_apply(input logic [31:0] w);
    int pos1, p, base, bi;
    pos1 = int'(w[24:16]);
    if (pos1 == 0) return 0;
    p = pos1 - 1;
    base = 8 * (p + p / 8) + (p % 8);
    for (int b = 0; b < 9; b++) begin
      if (w[b]) begin
        bi = base + b;
        if (bi / 8 < 512) gold[bi / 8] = gold[bi / 8] ^ 8'(1 << (bi % 8));
      end
    end
    return 1;
  endfunction

  task automatic run(input string req, input logic [31:0] stat,
                     input logic [31:0] w0, input logic [31:0] w1,
                     input logic [31:0] w2, input logic [31:0] w3,
                     input bit poke);
    int lim, applied, skipped, exp_cyc, n, bad, first_bad;
    logic [31:0] ws [4];
    ws[0] = w0; ws[1] = w1; ws[2] = w2; ws[3] = w3;
    applied = 0; skipped = 0;
    if (stat[1] || !stat[0]) begin
      exp_cyc = 2;
    end else begin
      lim = (int'(stat[31:29]) > 4) ? 4 : int'(stat[31:29]);
      for (int k = 0; k < lim; k++) begin
        if (gold_apply(ws[k]) == 1) applied++; else skipped++;
      end
      exp_cyc = 3 + 5 * applied + skipped;
    end
    wr_cnt = 0; oob_cnt = 0;
    @(negedge clk);
    status_word = stat;
    err_words = {w3, w2, w1, w0};
    start = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 200) begin
      if (poke && n == 3) begin
        start = 1'b1;
        status_word = st(3'd0, 1'b1, 1'b1);
        err_words = '0;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    // R10 / R3 completion timing
    chk(done && n == exp_cyc, req, "done edge (R10)", n, exp_cyc);
    chk(busy == 1'b1, req, "busy in done cycle (R8)", int'(busy), 1);
    chk(int'(fix_count) == applied, req, "fix_count (R9)", int'(fix_count), applied);
    chk(uncorrectable == stat[1], req, "uncorrectable (R2)", int'(uncorrectable), int'(stat[1]));
    @(posedge clk);
    @(negedge clk);
    chk(!done && !busy, req, "done one cycle then idle (R8)", int'(done) + 2 * int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(int'(fix_count) == applied && uncorrectable == stat[1], req,
        "results held (R9)", int'(fix_count), applied);
    bad = 0; first_bad = -1;
    for (int i = 0; i < 1024; i++) begin
      if (mem[i] !== gold[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    chk(bad == 0, req, "sector bytes mismatching (R5)", bad, 0);
    if (bad != 0) $display("  first differing byte index %0d", first_bad);
    chk(oob_cnt == 0, req, "writes at or above 512 (R7)", oob_cnt, 0);
    if (stat[1] || !stat[0]) chk(wr_cnt == 0, req, "RAM writes on fast path (R2 R3)", wr_cnt, 0);
    else chk(wr_cnt <= 2 * applied, req, "RAM write count (R5)", wr_cnt, 2 * applied);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !ram_en && !ram_we && !uncorrectable && fix_count == 0,
        "R12", "reset outputs", int'({busy, done, ram_en, ram_we, uncorrectable}), 0);
  endtask

  task automatic t_noerr();   // R3
    fill(1);
    run("R3", st(3'd3, 1'b0, 1'b0), ew(9'd5, 9'h1FF), ew(9'd9, 9'h0F0), ew(9'd20, 9'h001), '0, 1'b0);
  endtask

  task automatic t_uncorr();  // R2
    fill(2);
    run("R2", st(3'd2, 1'b1, 1'b1), ew(9'd5, 9'h1FF), ew(9'd9, 9'h0F0), '0, '0, 1'b0);
  endtask

  task automatic t_single();  // R1 R5: offset 0
    fill(3);
    run("R1", st(3'd1, 1'b0, 1'b1), ew(9'd1, 9'h1A5), '0, '0, '0, 1'b0);
    chk(mem[0] == (8'((0 * 37 + 3) & 255) ^ 8'hA5), "R5", "byte0 value",
        int'(mem[0]), int'(8'(3) ^ 8'hA5));
  endtask

  task automatic t_straddle(); // R5: offset 7 across bytes 7 and 8
    fill(4);
    run("R5", st(3'd1, 1'b0, 1'b1), ew(9'd8, 9'h1FF), '0, '0, '0, 1'b0);
    chk(mem[8] == (8'((8 * 37 + 4) & 255) ^ 8'hFF), "R5", "byte8 high part",
        int'(mem[8]), int'(8'((8 * 37 + 4) & 255) ^ 8'hFF));
  endtask

  task automatic t_four();     // R6: four reports, in order
    fill(5);
    run("R6", st(3'd4, 1'b0, 1'b1), ew(9'd64, 9'h155), ew(9'd2, 9'h0AA),
        ew(9'd3, 9'h1C3), ew(9'd300, 9'h011), 1'b0);
  endtask

  task automatic t_zero_pos(); // R4 R10
    fill(6);
    run("R4", st(3'd3, 1'b0, 1'b1), ew(9'd10, 9'h033), ew(9'd0, 9'h1FF), ew(9'd11, 9'h100), '0, 1'b0);
  endtask

  task automatic t_clip();     // R6: count 7 clipped to 4
    fill(7);
    run("R6", st(3'd7, 1'b0, 1'b1), ew(9'd17, 9'h001), ew(9'd33, 9'h002),
        ew(9'd49, 9'h004), ew(9'd65, 9'h008), 1'b0);
  endtask

  task automatic t_limit();    // R6: words past count ignored
    fill(8);
    run("R6", st(3'd2, 1'b0, 1'b1), ew(9'd40, 9'h0FF), ew(9'd41, 9'h1FF),
        ew(9'd42, 9'h1FF), ew(9'd43, 9'h1FF), 1'b0);
  endtask

  task automatic t_oob();      // R7: byte 511 written, 512 and beyond suppressed
    fill(9);
    run("R7", st(3'd2, 1'b0, 1'b1), ew(9'd456, 9'h1FF), ew(9'd500, 9'h1FF), '0, '0, 1'b0);
    chk(mem[512] == 8'((512 * 37 + 9) & 255), "R7", "byte512 untouched",
        int'(mem[512]), (512 * 37 + 9) & 255);
  endtask

  task automatic t_busy_start(); // R11
    fill(10);
    run("R11", st(3'd2, 1'b0, 1'b1), ew(9'd70, 9'h0C3), ew(9'd71, 9'h13C), '0, '0, 1'b1);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_noerr();
    t_uncorr();
    t_single();
    t_straddle();
    t_four();
    t_zero_pos();
    t_clip();
    t_limit();
    t_oob();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule